// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the CPU-facing control register file of a PCI host bridge. It sits on a 32-bit register bus and keeps a local 64-word copy of the bridge's own configuration header. It also holds three base registers. The first is a configuration target address. The second is a memory window base with most of its bits masked off. The third is an I/O window base with its own masking.

A single data port forwards CPU reads and writes as configuration transactions to a downstream request/acknowledge interface. The target address comes from the address register. The CPU access is stalled until the downstream side acknowledges.

Alongside the register file, the block decodes a 256 KiB I/O window in CPU address space. Its base moves with the I/O base register, and every hit is reported with the byte offset into I/O space. Interrupt levels from devices are routed to one of four outputs chosen by the device number.

Top module: `pcihb_regs`

## Requirements
- R1: Offsets 0x000 to 0x0FC (word aligned) read and write the 64 local header words in full 32 bits; after reset every word is zero except word 0 (the ID parameter, default zero) and word 1.
- R2: After reset, header word 1 reads 0x02900080: the command half has only bit 7 set (wait-cycle control), and the status half has bits 4, 7 and 9 set (capability list, fast back-to-back, medium DEVSEL timing).
- R3: Offset 0x1C0 holds the configuration target address; all 32 bits written read back unchanged, and the reset value is zero.
- R4: Offset 0x1C4 holds the memory base; a write keeps only bits 31:24 and bit 0, other bits read zero, and the reset value is zero.
- R5: Offset 0x1C8 holds the I/O base, reset 0xFE240000; a write keeps bits 31:18 and bit 0, but only when its bits 31:18 differ from the stored value; otherwise the write is dropped entirely, bit 0 included.
- R6: `win_hit` is high when `win_addr[31:18]` equals the I/O base bits 31:18, and `win_offset` equals `win_addr[17:0]`; both are combinational.
- R7: An access with size code 2'b10 to offset 0x220 raises `cfg_req` in the next cycle with `cfg_addr` equal to the target address register, `cfg_we` and `cfg_wdata` taken from the access. `rsp_ready` stays low until the cycle where `cfg_ack` is high. In that cycle a read returns `cfg_rdata`. `cfg_req` drops in the following cycle.
- R8: Reads of any other offset (unaligned, 0x100 to 0x1BC, 0x1CC to 0x21C, above 0x220) return zero, and writes there change no register.
- R9: An access with size code other than 2'b10 completes in the same cycle with `rsp_err` high and read data zero. It changes no register and starts no downstream transaction.
- R10: When `irq_set` is high, output number `irq_devfn >> 3` takes the value of `irq_level` on the next clock. Device numbers of 4 and above change no output. All outputs are low after reset.
- R11: Every valid 32-bit access to an offset other than 0x220 is answered with `rsp_ready` high in the same cycle as `req_valid`, with `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access present; held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code; 2'b10 = 32-bit |
| req_addr | input | ADDR_W (12) | Byte offset in the register block |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Access completes this cycle |
| rsp_err | output | 1 | Access rejected (bad size) |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| cfg_req | output | 1 | Downstream configuration transaction pending |
| cfg_we | output | 1 | Downstream transaction is a write |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Downstream transaction complete |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ack` |
| win_addr | input | 32 | CPU address to test against the I/O window |
| win_hit | output | 1 | Address falls inside the I/O window |
| win_offset | output | WIN_BITS (18) | Offset into I/O space |
| irq_set | input | 1 | Update one interrupt line |
| irq_devfn | input | 8 | Device/function number of the source |
| irq_level | input | 1 | New interrupt level |
| irq_out | output | NIRQ (4) | Routed interrupt outputs |

## Verification
A corrupted I/O base shows on `win_hit` at the very next clock for any address that straddles the old and new window. The bench therefore compares the window and interrupt outputs against its model on every cycle, not only after accesses. A wrong base, address or header word is otherwise hidden until software reads it back. For that reason every register write is followed by a read, and every data-port transaction is checked on `cfg_addr` in its first pending cycle. Stall errors in the data port show as `rsp_ready` rising before `cfg_ack`, and the bench looks for this on every waiting cycle at several acknowledge delays.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;
  localparam logic [11:0] OFF_TADDR = 12'h1C0;
  localparam logic [11:0] OFF_MBASE = 12'h1C4;
  localparam logic [11:0] OFF_IOBASE = 12'h1C8;
  localparam logic [11:0] OFF_DPORT = 12'h220;
  localparam logic [1:0] SIZE_WORD = 2'b10;
  localparam logic [15:0] CMD_RESET = 16'h0080;
  localparam logic [15:0] STAT_RESET = 16'h0290;
  typedef enum logic {PORT_IDLE, PORT_BUSY} port_state_e;
endpackage

// File: rtl/pcihb_hdr.sv
module pcihb_hdr #(
  parameter int HDR_WORDS = 64,
  parameter logic [31:0] ID_WORD = 32'h0,
  localparam int IDX_W = $clog2(HDR_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  import pcihb_pkg::*;

  logic [31:0] words [HDR_WORDS];

  function automatic logic [31:0] reset_word(int i);
    if (i == 0) return ID_WORD;
    if (i == 1) return {STAT_RESET, CMD_RESET};
    return 32'h0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_WORDS; i++) words[i] <= reset_word(i);
    end else if (we) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];
endmodule

// File: rtl/pcihb_bases.sv
module pcihb_bases #(
  parameter int WIN_BITS = 18,
  parameter logic [31:0] IOBASE_RESET = 32'hFE24_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_taddr,
  input  logic                we_mbase,
  input  logic                we_iobase,
  input  logic [31:0]         wdata,
  output logic [31:0]         taddr,
  output logic [31:0]         mbase,
  output logic [31:0]         iobase,
  input  logic [31:0]         win_addr,
  output logic                win_hit,
  output logic [WIN_BITS-1:0] win_offset
);
  localparam logic [31:0] MBASE_KEEP = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_KEEP = ({32{1'b1}} << WIN_BITS) | 32'h1;

  logic [31:0] taddr_d, mbase_d, iobase_d;
  logic        io_moves;

  assign io_moves = wdata[31:WIN_BITS] != iobase[31:WIN_BITS];

  always_comb begin
    taddr_d  = taddr;
    mbase_d  = mbase;
    iobase_d = iobase;
    if (we_taddr) taddr_d = wdata;
    if (we_mbase) mbase_d = wdata & MBASE_KEEP;
    if (we_iobase && io_moves) iobase_d = wdata & IOBASE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr  <= 32'h0;
      mbase  <= 32'h0;
      iobase <= IOBASE_RESET & IOBASE_KEEP;
    end else begin
      taddr  <= taddr_d;
      mbase  <= mbase_d;
      iobase <= iobase_d;
    end
  end

  assign win_hit    = win_addr[31:WIN_BITS] == iobase[31:WIN_BITS];
  assign win_offset = win_addr[WIN_BITS-1:0];

  AST_IOBASE_SAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_iobase && wdata[31:WIN_BITS] == iobase[31:WIN_BITS]) |=> $stable(iobase)); // R5
  AST_MBASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_mbase |=> $stable(mbase)); // R4
endmodule

// File: rtl/pcihb_cfgport.sv
module pcihb_cfgport (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_ack,
  output logic busy,
  output logic done
);
  import pcihb_pkg::*;

  port_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PORT_IDLE: if (start) state_d = PORT_BUSY;
      PORT_BUSY: if (cfg_ack) state_d = PORT_IDLE;
      default:   state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PORT_IDLE;
    else        state_q <= state_d;
  end

  assign busy = state_q == PORT_BUSY;
  assign done = busy && cfg_ack;

  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
endmodule

// File: rtl/pcihb_irqmap.sv
module pcihb_irqmap #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_set,
  input  logic [7:0]      irq_devfn,
  input  logic            irq_level,
  output logic [NIRQ-1:0] irq_out
);
  logic [7:0] dev_num;
  assign dev_num = irq_devfn >> 3;

  for (genvar gi = 0; gi < NIRQ; gi++) begin : g_line
    logic hit, d;
    assign hit = irq_set && (dev_num == 8'(gi));
    always_comb d = hit ? irq_level : irq_out[gi];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out[gi] <= 1'b0;
      else        irq_out[gi] <= d;
    end
  end

  AST_HIGH_DEV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && dev_num >= 8'(NIRQ)) |=> $stable(irq_out)); // R10
endmodule

// File: rtl/pcihb_regs.sv
module pcihb_regs #(
  parameter int ADDR_W = 12,
  parameter int HDR_WORDS = 64,
  parameter int WIN_BITS = 18,
  parameter int NIRQ = 4,
  parameter logic [31:0] ID_WORD = 32'h0,
  parameter logic [31:0] IOBASE_RESET = 32'hFE24_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_ready,
  output logic                rsp_err,
  output logic [31:0]         rsp_rdata,
  output logic                cfg_req,
  output logic                cfg_we,
  output logic [31:0]         cfg_addr,
  output logic [31:0]         cfg_wdata,
  input  logic                cfg_ack,
  input  logic [31:0]         cfg_rdata,
  input  logic [31:0]         win_addr,
  output logic                win_hit,
  output logic [WIN_BITS-1:0] win_offset,
  input  logic                irq_set,
  input  logic [7:0]          irq_devfn,
  input  logic                irq_level,
  output logic [NIRQ-1:0]     irq_out
);
  import pcihb_pkg::*;

  localparam int IDX_W = $clog2(HDR_WORDS);
  localparam int HDR_BYTES = HDR_WORDS * 4;

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_i = rst_s1;

  // decode
  logic size_ok, acc_ok, is_hdr, is_taddr, is_mbase, is_iobase, is_dport;
  assign size_ok   = req_size == SIZE_WORD;
  assign acc_ok    = req_valid && size_ok;
  assign is_hdr    = (32'(req_addr) < 32'(HDR_BYTES)) && (req_addr[1:0] == 2'b00);
  assign is_taddr  = req_addr == ADDR_W'(OFF_TADDR);
  assign is_mbase  = req_addr == ADDR_W'(OFF_MBASE);
  assign is_iobase = req_addr == ADDR_W'(OFF_IOBASE);
  assign is_dport  = req_addr == ADDR_W'(OFF_DPORT);

  logic wr_ok;
  assign wr_ok = acc_ok && req_write;

  logic [31:0] hdr_rdata, taddr, mbase, iobase;
  logic        port_busy, port_done;

  pcihb_hdr #(.HDR_WORDS(HDR_WORDS), .ID_WORD(ID_WORD)) u_hdr (
    .clk   (clk),
    .rst_n (rst_i),
    .we    (wr_ok && is_hdr),
    .idx   (req_addr[IDX_W+1:2]),
    .wdata (req_wdata),
    .rdata (hdr_rdata)
  );

  pcihb_bases #(.WIN_BITS(WIN_BITS), .IOBASE_RESET(IOBASE_RESET)) u_bases (
    .clk        (clk),
    .rst_n      (rst_i),
    .we_taddr   (wr_ok && is_taddr),
    .we_mbase   (wr_ok && is_mbase),
    .we_iobase  (wr_ok && is_iobase),
    .wdata      (req_wdata),
    .taddr      (taddr),
    .mbase      (mbase),
    .iobase     (iobase),
    .win_addr   (win_addr),
    .win_hit    (win_hit),
    .win_offset (win_offset)
  );

  pcihb_cfgport u_port (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (acc_ok && is_dport && !port_busy),
    .cfg_ack (cfg_ack),
    .busy    (port_busy),
    .done    (port_done)
  );

  pcihb_irqmap #(.NIRQ(NIRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_i),
    .irq_set   (irq_set),
    .irq_devfn (irq_devfn),
    .irq_level (irq_level),
    .irq_out   (irq_out)
  );

  assign cfg_req   = port_busy;
  assign cfg_we    = req_write;
  assign cfg_addr  = taddr;
  assign cfg_wdata = req_wdata;

  assign rsp_err   = req_valid && !size_ok;
  assign rsp_ready = (req_valid && (!size_ok || !is_dport)) || port_done;

  always_comb begin
    rsp_rdata = 32'h0;
    if (acc_ok && !req_write) begin
      if (is_hdr)         rsp_rdata = hdr_rdata;
      else if (is_taddr)  rsp_rdata = taddr;
      else if (is_mbase)  rsp_rdata = mbase;
      else if (is_iobase) rsp_rdata = iobase;
      else if (is_dport)  rsp_rdata = port_done ? cfg_rdata : 32'h0;
    end
  end

  AST_ERR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_err |-> (rsp_ready && rsp_rdata == 32'h0)); // R9
  AST_BADSIZE_NO_CFG: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && !size_ok && !port_busy) |=> !cfg_req); // R9
  AST_DPORT_WAITS: assert property (@(posedge clk) disable iff (!rst_i)
    (acc_ok && is_dport && !cfg_ack) |-> !rsp_ready); // R7
  AST_CFG_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_req && $past(cfg_req)) |-> $stable(cfg_addr)); // R7
endmodule

// File: tb/tb_pcihb_regs.sv
`timescale 1ns/1ps
module tb_pcihb_regs;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack;
  logic [31:0] cfg_rdata;
  logic [31:0] win_addr;
  logic        win_hit;
  logic [17:0] win_offset;
  logic        irq_set, irq_level;
  logic [7:0]  irq_devfn;
  logic [3:0]  irq_out;

  pcihb_regs dut (.*);

  int checks = 0;
  int errors = 0;
  bit live = 0;

  // behavioural model
  logic [31:0] m_hdr [64];
  logic [31:0] m_taddr, m_mbase, m_iobase;
  logic [3:0]  m_irq;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a < 12'h100 && a[1:0] == 2'b00) return m_hdr[a[7:2]];
    if (a == 12'h1C0) return m_taddr;
    if (a == 12'h1C4) return m_mbase;
    if (a == 12'h1C8) return m_iobase;
    return 32'h0;
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    if (a < 12'h100 && a[1:0] == 2'b00) m_hdr[a[7:2]] = d;
    else if (a == 12'h1C0) m_taddr = d;
    else if (a == 12'h1C4) m_mbase = d & 32'hFF00_0001;
    else if (a == 12'h1C8) begin
      if (d[31:18] != m_iobase[31:18]) m_iobase = d & 32'hFFFC_0001;
    end
  endtask

  // every-cycle comparison of window and interrupt outputs
  always @(negedge clk) begin
    if (live) begin
      chk("R6 hit", 32'(win_hit), 32'(win_addr[31:18] == m_iobase[31:18]));
      chk("R6 offset", 32'(win_offset), 32'(win_addr[17:0]));
      chk("R10 irq", 32'(irq_out), 32'(m_irq));
    end
  end

  // register access, completes in the same cycle
  task automatic acc(string req, logic w, logic [11:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_size = sz;
    #1;
    chk({req, " ready"}, 32'(rsp_ready), 32'h1);
    chk({req, " err"}, 32'(rsp_err), 32'(sz != 2'b10));
    if (!w) chk({req, " rdata"}, rsp_rdata, (sz == 2'b10) ? m_read(a) : 32'h0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (w && sz == 2'b10) m_write(a, d);
  endtask

  task automatic wr_rd(string req, logic [11:0] a, logic [31:0] d);
    acc(req, 1'b1, a, d, 2'b10);
    acc(req, 1'b0, a, 32'h0, 2'b10);
  endtask

  // data-port access with a downstream responder
  task automatic dport(logic w, logic [31:0] d, int dly, logic [31:0] resp);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 12'h220; req_wdata = d; req_size = 2'b10;
    #1;
    chk("R7 stall before start", 32'(rsp_ready), 32'h0);
    @(posedge clk);
    #1;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R7 req", 32'(cfg_req), 32'h1);
      chk("R7 addr", cfg_addr, m_taddr);
      chk("R7 we", 32'(cfg_we), 32'(w));
      if (w) chk("R7 wdata", cfg_wdata, d);
      chk("R7 stall", 32'(rsp_ready), 32'h0);
    end
    @(negedge clk);
    chk("R7 req at ack", 32'(cfg_req), 32'h1);
    chk("R7 addr at ack", cfg_addr, m_taddr);
    cfg_ack = 1'b1; cfg_rdata = resp;
    #1;
    chk("R7 ready on ack", 32'(rsp_ready), 32'h1);
    chk("R7 err", 32'(rsp_err), 32'h0);
    if (!w) chk("R7 rdata", rsp_rdata, resp);
    @(posedge clk);
    #1;
    req_valid = 1'b0; cfg_ack = 1'b0;
    @(negedge clk);
    chk("R7 req drops", 32'(cfg_req), 32'h0);
  endtask

  task automatic irq(logic [7:0] devfn, logic lvl);
    @(negedge clk);
    irq_set = 1'b1; irq_devfn = devfn; irq_level = lvl;
    @(posedge clk);
    #1;
    irq_set = 1'b0;
    if ((devfn >> 3) < 4) m_irq[devfn >> 3] = lvl;
  endtask

  task automatic set_win(logic [31:0] a);
    @(posedge clk);
    #1 win_addr = a;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_size = 2'b10; req_addr = 0; req_wdata = 0;
    cfg_ack = 0; cfg_rdata = 0; win_addr = 32'hFE24_0010;
    irq_set = 0; irq_devfn = 0; irq_level = 0;
    for (int i = 0; i < 64; i++) m_hdr[i] = 32'h0;
    m_hdr[1] = 32'h0290_0080;
    m_taddr = 0; m_mbase = 0; m_iobase = 32'hFE24_0000; m_irq = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    live = 1;
    // reset state
    chk("R7 reset cfg_req", 32'(cfg_req), 32'h0);
    chk("R10 reset irq", 32'(irq_out), 32'h0);
    chk("R6 reset hit", 32'(win_hit), 32'h1);
    chk("R6 reset offset", 32'(win_offset), 32'h10);
    acc("R1 id", 1'b0, 12'h000, 0, 2'b10);
    acc("R2 cmd/status", 1'b0, 12'h004, 0, 2'b10);
    acc("R1 word 63", 1'b0, 12'h0FC, 0, 2'b10);
    acc("R3 reset", 1'b0, 12'h1C0, 0, 2'b10);
    acc("R4 reset", 1'b0, 12'h1C4, 0, 2'b10);
    acc("R5 reset", 1'b0, 12'h1C8, 0, 2'b10);
    // header words, R11 single-cycle covered in acc
    wr_rd("R1 word 5", 12'h014, 32'hA5A5_1234);
    wr_rd("R1 word 63", 12'h0FC, 32'hFFFF_FFFF);
    wr_rd("R1 word 1", 12'h004, 32'h1234_5678);
    wr_rd("R11 word 0", 12'h000, 32'h0BAD_F00D);
    acc("R1 word 5 kept", 1'b0, 12'h014, 0, 2'b10);
    // target address
    wr_rd("R3", 12'h1C0, 32'hDEAD_BEEF);
    // memory base
    wr_rd("R4 all ones", 12'h1C4, 32'hFFFF_FFFF);
    wr_rd("R4 pattern", 12'h1C4, 32'h1234_5678);
    // I/O base
    wr_rd("R5 same base", 12'h1C8, 32'hFE27_FFFF);
    wr_rd("R5 move", 12'h1C8, 32'h1003_FFFF);
    wr_rd("R5 same base bit0", 12'h1C8, 32'h1000_0000);
    set_win(32'h1000_0000);
    chk("R6 first byte", 32'(win_hit), 32'h1);
    set_win(32'h1003_FFFF);
    chk("R6 last byte", 32'(win_offset), 32'h3FFFF);
    set_win(32'h1004_0000);
    chk("R6 past end", 32'(win_hit), 32'h0);
    set_win(32'h0FFF_FFFF);
    chk("R6 below", 32'(win_hit), 32'h0);
    set_win(32'hFE24_0000);
    chk("R6 old base", 32'(win_hit), 32'h0);
    wr_rd("R5 move back", 12'h1C8, 32'hFE24_0001);
    set_win(32'hFE25_2345);
    chk("R6 moved hit", 32'(win_hit), 32'h1);
    // undefined offsets
    acc("R8 write 0x104", 1'b1, 12'h104, 32'hFFFF_FFFF, 2'b10);
    acc("R8 read 0x104", 1'b0, 12'h104, 0, 2'b10);
    acc("R8 write 0x1CC", 1'b1, 12'h1CC, 32'h5555_5555, 2'b10);
    acc("R8 read 0x1CC", 1'b0, 12'h1CC, 0, 2'b10);
    acc("R8 read 0x224", 1'b0, 12'h224, 0, 2'b10);
    acc("R8 write unaligned", 1'b1, 12'h1C2, 32'h0, 2'b10);
    acc("R8 taddr kept", 1'b0, 12'h1C0, 0, 2'b10);
    acc("R8 write unaligned hdr", 1'b1, 12'h016, 32'h0, 2'b10);
    acc("R8 hdr kept", 1'b0, 12'h014, 0, 2'b10);
    // size errors
    acc("R9 bad write taddr", 1'b1, 12'h1C0, 32'h0, 2'b01);
    acc("R9 taddr kept", 1'b0, 12'h1C0, 0, 2'b10);
    acc("R9 bad write iobase", 1'b1, 12'h1C8, 32'h2000_0000, 2'b00);
    acc("R9 iobase kept", 1'b0, 12'h1C8, 0, 2'b10);
    acc("R9 bad read", 1'b0, 12'h004, 0, 2'b11);
    acc("R9 bad dport", 1'b1, 12'h220, 32'h1, 2'b01);
    @(negedge clk);
    chk("R9 no cfg", 32'(cfg_req), 32'h0);
    // data port
    wr_rd("R3 cfg target", 12'h1C0, 32'h8000_0810);
    dport(1'b1, 32'h1122_3344, 3, 32'h0);
    dport(1'b0, 32'h0, 0, 32'hCAFE_F00D);
    wr_rd("R3 cfg target 2", 12'h1C0, 32'h8000_1804);
    dport(1'b0, 32'h0, 5, 32'h0123_4567);
    dport(1'b1, 32'hFFFF_0000, 1, 32'h0);
    // interrupts
    irq(8'h00, 1'b1);
    irq(8'h1F, 1'b1);
    irq(8'h09, 1'b1);
    irq(8'h20, 1'b1);
    irq(8'hFF, 1'b0);
    irq(8'h02, 1'b0);
    @(negedge clk);
    chk("R10 final", 32'(irq_out), 32'b1010);
    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule